// File: doc/BRIEF.md
# Eight-Operation Arithmetic, Logic and Shift Unit

This block is the execute-stage arithmetic unit of a small 16-bit processor datapath. It takes a first operand, a second operand and a 3-bit operation select, and computes one of eight results: sum, difference, bitwise AND, bitwise NAND, bitwise OR, bitwise exclusive-OR, left shift or arithmetic right shift. Alongside the result it reports a zero indicator and a negative indicator.

The register form and the immediate form of an instruction both reach this unit through the same select code. The surrounding datapath chooses between a register value and a sign-extended immediate before the second operand arrives here. Decode, operand selection and writeback all live outside the block. In keeping with an FPGA-oriented pipeline, the result and both flags are registered. Each operation therefore shows its outcome one clock edge after its operands are presented. A synchronous active-high reset clears the output register.

Top module: `alu_op8`

## Requirements
- R1: With select 000, the result is first operand plus second operand, modulo 2^16, and no carry is reported.
- R2: With select 001, the result is first operand minus second operand, modulo 2^16.
- R3: With select 010, the result is the bitwise AND of the operands.
- R4: With select 011, the result is the bitwise NAND of the operands.
- R5: With select 100, the result is the bitwise OR of the operands.
- R6: With select 101, the result is the bitwise exclusive-OR of the operands.
- R7: With select 110, the result is the first operand shifted left by second-operand bits [3:0] (0 to 15), with zeros filled in. Bits [15:4] of the second operand have no effect.
- R8: With select 111, the result is the first operand shifted right by second-operand bits [3:0], and every vacated bit is filled with first-operand bit 15.
- R9: The zero flag is 1 exactly when the registered result is all zeros.
- R10: The negative flag equals bit 15 of the registered result.
- R11: The result and flags for the inputs present at a rising clock edge appear after that edge. A clock edge with reset high sets the result to 0, the zero flag to 1 and the negative flag to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand; bits [3:0] give the shift amount |
| sel | input | 3 | Operation select |
| res | output | 16 | Registered result |
| zf | output | 1 | Registered zero flag |
| nf | output | 1 | Registered negative flag |

## Verification
The embedded properties check the following on every cycle:
- Both flags stay consistent with the registered result.
- A right shift keeps the sign of its operand.
- A zero shift amount passes the operand through unchanged.
- Subtracting an operand from itself raises the zero flag.
- A reset edge clears the output.

Only the bench's scenarios can show that each select value yields the correct value for arbitrary operands. The bench uses random and corner-case operands for this: wraparound at 0xFFFF and 0x8000, shift amounts at 0 and 15, and high second-operand bits that must not change a shift.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_AND  = 3'b010,
    OP_NAND = 3'b011,
    OP_OR   = 3'b100,
    OP_EOR  = 3'b101,
    OP_ASL  = 3'b110,
    OP_ASR  = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic zero;
    logic neg;
  } alu_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  logic [W-1:0] b_eff;

  // two's-complement subtract: invert b and add one through the carry in
  assign b_eff = sub ? ~b : b;
  assign y     = a + b_eff + {{(W-1){1'b0}}, sub};
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,   // 00 and, 01 nand, 10 or, 11 eor
  output logic [W-1:0] y
);
  always_comb begin
    unique case (fn)
      2'b00:   y = a & b;
      2'b01:   y = ~(a & b);
      2'b10:   y = a | b;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W  = 16,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] amt,
  input  logic          right,
  output logic [W-1:0]  y
);
  logic [SW:0][W-1:0] stg;
  logic               fill;

  assign fill   = right & a[W-1];
  assign stg[0] = a;

  // log-depth barrel: stage i moves by 2**i when amt[i] is set
  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int SH = 1 << i;
    logic [W-1:0] moved;
    assign moved = right ? {{SH{fill}}, stg[i][W-1:SH]}
                         : {stg[i][W-1-SH:0], {SH{1'b0}}};
    assign stg[i+1] = amt[i] ? moved : stg[i];
  end

  assign y = stg[SW];
endmodule

// File: rtl/alu_op8.sv
module alu_op8 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   sel,
  output logic [W-1:0] res,
  output logic         zf,
  output logic         nf
);
  import alu_pkg::*;

  localparam int SW = $clog2(W);

  alu_op_e    op;
  logic [W-1:0] as_y, lg_y, sh_y, nxt;
  alu_flags_t fl_nxt;

  assign op = alu_op_e'(sel);

  alu_addsub #(.W(W)) u_addsub (
    .a(opa), .b(opb), .sub(op == OP_SUB), .y(as_y)
  );

  alu_logic #(.W(W)) u_logic (
    .a(opa), .b(opb), .fn({sel[2], sel[0]}), .y(lg_y)
  );

  alu_shift #(.W(W), .SW(SW)) u_shift (
    .a(opa), .amt(opb[SW-1:0]), .right(sel[0]), .y(sh_y)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:                 nxt = as_y;
      OP_AND, OP_NAND, OP_OR, OP_EOR: nxt = lg_y;
      default:                        nxt = sh_y;
    endcase
    fl_nxt.zero = (nxt == '0);
    fl_nxt.neg  = nxt[W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res <= '0;
      zf  <= 1'b1;
      nf  <= 1'b0;
    end else begin
      res <= nxt;
      zf  <= fl_nxt.zero;
      nf  <= fl_nxt.neg;
    end
  end

  // flag registers agree with the result register
  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    zf == (res == '0));
  p_neg_flag_r10: assert property (@(posedge clk) disable iff (rst)
    nf == res[W-1]);

  // a reset edge leaves the cleared state
  p_reset_r11: assert property (@(posedge clk)
    rst |=> (res == '0 && zf && !nf));

  // arithmetic right shift keeps the sign of the first operand
  p_asr_sign_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) == OP_ASR) |-> res[W-1] == $past(opa[W-1]));

  // a shift by zero returns the first operand unchanged
  p_shift_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel[2:1]) == 2'b11 && $past(opb[SW-1:0]) == '0)
      |-> res == $past(opa));

  // an operand minus itself is zero
  p_sub_self_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) == OP_SUB && $past(opa) == $past(opb)) |-> zf);
endmodule

// File: tb/sim_alu_op8.sv
`timescale 1ns/1ps
module sim_alu_op8;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opa = '0, opb = '0;
  logic [2:0]  sel = '0;
  logic [15:0] res;
  logic        zf, nf;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_op8 u0 (.clk(clk), .rst(rst), .opa(opa), .opb(opb), .sel(sel),
              .res(res), .zf(zf), .nf(nf));

  function automatic logic [15:0] model(input logic [2:0] op,
                                        input logic [15:0] a,
                                        input logic [15:0] b);
    int n;
    int sa;
    longint s;
    n  = b[3:0];
    sa = int'($signed(a));
    case (op)
      3'd0: s = longint'(a) + longint'(b);
      3'd1: s = longint'(a) - longint'(b) + 65536;
      3'd2: s = a & b;
      3'd3: s = ~(a & b);
      3'd4: s = a | b;
      3'd5: s = a ^ b;
      3'd6: s = longint'(a) * (longint'(1) << n);
      default: begin
        s = 0;
        for (int k = 0; k < 16; k++) begin
          int src;
          src = k + n;
          if (src > 15) s = s | (longint'(a[15]) << k);
          else          s = s | (longint'(a[src]) << k);
        end
        if (sa < 0 && n == 0) s = a;
      end
    endcase
    return s[15:0];
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] exp_r;
    @(negedge clk);
    sel = op; opa = a; opb = b;
    exp_r = model(op, a, b);
    @(negedge clk);
    checks++;
    if (res !== exp_r) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h res actual=%h expected=%h",
               tag(op), op, a, b, res, exp_r);
    end
    checks++;
    if (zf !== (exp_r == 16'h0)) begin
      errors++;
      $display("FAIL R9 zero flag actual=%b expected=%b", zf, exp_r == 16'h0);
    end
    checks++;
    if (nf !== exp_r[15]) begin
      errors++;
      $display("FAIL R10 negative flag actual=%b expected=%b", nf, exp_r[15]);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] corner [0:7];
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h7FFF;
    corner[3] = 16'h8000; corner[4] = 16'hFFFF; corner[5] = 16'h00FF;
    corner[6] = 16'hA5A5; corner[7] = 16'h000F;

    // R11: reset state
    repeat (2) @(negedge clk);
    checks++;
    if (res !== 16'h0 || zf !== 1'b1 || nf !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset actual=%h/%b/%b expected=0000/1/0", res, zf, nf);
    end
    rst = 1'b0;

    // R1 wraparound, R2 borrow wrap, R2 self-subtract to zero
    run(3'd0, 16'hFFFF, 16'h0001);
    run(3'd0, 16'h7FFF, 16'h0001);
    run(3'd1, 16'h0000, 16'h0001);
    run(3'd1, 16'h1234, 16'h1234);
    // R3..R6 logic patterns
    run(3'd2, 16'hF0F0, 16'h0FF0);
    run(3'd3, 16'hFFFF, 16'hFFFF);
    run(3'd4, 16'h0000, 16'h0000);
    run(3'd5, 16'hAAAA, 16'h5555);
    // R7 limits and ignored upper shift bits
    run(3'd6, 16'h0001, 16'h000F);
    run(3'd6, 16'h1234, 16'h0000);
    run(3'd6, 16'h0001, 16'hFFF3);
    run(3'd6, 16'h8001, 16'h0001);
    // R8 sign fill on both signs
    run(3'd7, 16'h8000, 16'h000F);
    run(3'd7, 16'h7FFF, 16'h000F);
    run(3'd7, 16'hF0F0, 16'h0004);
    run(3'd7, 16'h8421, 16'hFFF0);

    // every operation over the corner operand grid
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run(op[2:0], corner[i], corner[j]);

    // random operands
    for (int n = 0; n < 2000; n++)
      run($urandom_range(0, 7), 16'($urandom), 16'($urandom));

    // R11: reset mid-run clears the output at the next edge
    @(negedge clk);
    sel = 3'd5; opa = 16'hFFFF; opb = 16'h0000; rst = 1'b1;
    @(negedge clk);
    checks++;
    if (res !== 16'h0 || zf !== 1'b1 || nf !== 1'b0) begin
      errors++;
      $display("FAIL R11 mid-run reset actual=%h/%b/%b expected=0000/1/0", res, zf, nf);
    end
    rst = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule